// File: doc/BRIEF.md
# Big-endian byte-lane word memory

This block is a small store of 32-bit words, such as a configuration store, that sits behind a simple request port. Each request carries a byte offset, a transfer size and a direction. Byte, halfword and word transfers are all accepted. The word is selected by the offset shifted right by two. The lane inside the word is numbered big-endian, so the lowest offset names the most significant byte.

A read takes the addressed lane out of the stored word and returns it right-justified and zero-extended, one clock after the request. A byte or halfword write merges the new lane into the stored word and leaves the other bits alone. A word write replaces the whole word. A request that is not aligned to its own size, or whose offset lies past the end of the store, is refused: it changes nothing and returns an error flag with zero data. Reset clears every word.

Top module: `be_lane_mem`

## Requirements
- R1: The word index is the request offset shifted right by two, and a word read (size 2) returns the whole stored word on `rsp_rdata` in the cycle after the request.
- R2: A byte read (size 0) at offset bits [1:0] = 0, 1, 2, 3 returns word bits 31:24, 23:16, 15:8, 7:0 in `rsp_rdata[7:0]`, with bits 31:8 zero.
- R3: A halfword read (size 1) returns word bits 15:0 when offset bit 1 is set and bits 31:16 when it is clear, in `rsp_rdata[15:0]`, with bits 31:16 zero.
- R4: A byte or halfword write stores `req_wdata[7:0]` or `req_wdata[15:0]` into the lane that the R2/R3 read mapping names, and leaves every other bit of that word unchanged.
- R5: A word write replaces all 32 bits of the addressed word with `req_wdata`.
- R6: After reset every word reads as zero and `rsp_valid`, `rsp_err` and `rsp_rdata` are zero.
- R7: A halfword request with offset bit 0 set, or a word request with offset bits [1:0] nonzero, sets `rsp_err`, returns zero data and does not change the store.
- R8: A byte, halfword or word request whose offset is at or beyond 4 × WORDS sets `rsp_err`, returns zero data and does not change the store.
- R9: Size 3 is a no-operation: no error, zero data, and no change to the store.
- R10: `rsp_valid` is high exactly in the cycle after each cycle with `req_valid` high, `rsp_err` is only high with `rsp_valid`, and a write response carries zero data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 no-operation |
| req_addr | input | ADDR_W | Byte offset into the store |
| req_wdata | input | 32 | Write data, right-justified for byte and halfword |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_err | output | 1 | Request refused (misaligned or out of range) |
| rsp_rdata | output | 32 | Right-justified, zero-extended read data |

## Verification
Aligned word writes of distinct patterns followed by reads of every byte lane and both halves tell apart a correct big-endian mapping from a little-endian or a swapped-half one. Single-lane writes of a marker into a word prefilled with a known pattern separate a true merge from a whole-word overwrite or a write to the wrong lane. Misaligned, out-of-range and size-3 requests, each followed by a read of the word they aimed at, show whether a refused request leaks into the store. A long mixed run of random sizes, offsets and directions is compared every clock against a behavioural model of the store.

// File: rtl/be_mem_pkg.sv
package be_mem_pkg;

   // Fixed geometry of one stored word.
   localparam int WORD_W = 32;
   localparam int LANE_W = 8;
   localparam int LANES  = WORD_W / LANE_W;
   localparam int LSEL_W = $clog2(LANES);

   // Transfer size encoding seen on the request port.
   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2,
      SZ_NONE = 2'd3
   } xfer_size_e;

   // Result of decoding one request offset.
   typedef struct packed {
      logic              acc_ok;   // legal, sized access
      logic              acc_err;  // refused access
      logic [LANES-1:0]  lane_en;  // bit k covers word bits 8k+7:8k
      logic [LSEL_W-1:0] rshift;   // right shift in lanes for a read
   } lane_dec_t;

endpackage

// File: rtl/be_addr_decode.sv
module be_addr_decode
   import be_mem_pkg::*;
#(
   parameter int WORDS  = 16,
   parameter int ADDR_W = 8,
   parameter int IDX_W  = 4
) (
   input  logic [ADDR_W-1:0] addr,
   input  xfer_size_e        size,
   output logic [IDX_W-1:0]  idx,
   output lane_dec_t         dec
);

   localparam int WSEL_W = ADDR_W - 2;

   logic [WSEL_W-1:0] word_sel;
   logic [1:0]        off;
   logic              misalign;
   logic              out_range;
   logic              sized;

   assign word_sel = addr[ADDR_W-1:2];
   assign off      = addr[1:0];
   assign idx      = word_sel[IDX_W-1:0];
   assign sized    = (size != SZ_NONE);

   // Alignment rule: halfwords on even offsets, words on multiples of four.
   always_comb begin
      case (size)
         SZ_HALF: misalign = off[0];
         SZ_WORD: misalign = (off != 2'b00);
         default: misalign = 1'b0;
      endcase
   end

   // Range rule: the word selected must exist.
   assign out_range = (32'(word_sel) >= 32'(WORDS));

   // Lane enables in big-endian numbering: offset 0 is the top lane.
   always_comb begin
      dec.lane_en = '0;
      dec.rshift  = '0;
      case (size)
         SZ_BYTE: begin
            dec.lane_en = 4'b1000 >> off;
            dec.rshift  = 2'd3 - off;
         end
         SZ_HALF: begin
            dec.lane_en = off[1] ? 4'b0011 : 4'b1100;
            dec.rshift  = off[1] ? 2'd0 : 2'd2;
         end
         SZ_WORD: begin
            dec.lane_en = 4'b1111;
            dec.rshift  = 2'd0;
         end
         default: begin
            dec.lane_en = 4'b0000;
            dec.rshift  = 2'd0;
         end
      endcase
   end

   assign dec.acc_err = sized & (misalign | out_range);
   assign dec.acc_ok  = sized & ~misalign & ~out_range;

endmodule

// File: rtl/be_lane_merge.sv
module be_lane_merge
   import be_mem_pkg::*;
(
   input  logic [WORD_W-1:0] old_word,
   input  logic [WORD_W-1:0] wdata,
   input  xfer_size_e        size,
   input  logic [LANES-1:0]  lane_en,
   output logic [WORD_W-1:0] new_word
);

   logic [WORD_W-1:0] placed;

   // Copy the right-justified data into every lane position it may take;
   // the lane enables then pick the ones that are really written.
   always_comb begin
      case (size)
         SZ_BYTE: placed = {LANES{wdata[LANE_W-1:0]}};
         SZ_HALF: placed = {(LANES/2){wdata[2*LANE_W-1:0]}};
         default: placed = wdata;
      endcase
   end

   for (genvar k = 0; k < LANES; k++) begin : g_lane
      assign new_word[k*LANE_W +: LANE_W] =
         lane_en[k] ? placed[k*LANE_W +: LANE_W] : old_word[k*LANE_W +: LANE_W];
   end

endmodule

// File: rtl/be_lane_extract.sv
module be_lane_extract
   import be_mem_pkg::*;
(
   input  logic [WORD_W-1:0] word,
   input  logic [LSEL_W-1:0] rshift,
   input  xfer_size_e        size,
   output logic [WORD_W-1:0] data
);

   logic [WORD_W-1:0] shifted;
   logic [WORD_W-1:0] keep;

   assign shifted = word >> {rshift, 3'b000};

   always_comb begin
      case (size)
         SZ_BYTE: keep = {{(WORD_W-LANE_W){1'b0}}, {LANE_W{1'b1}}};
         SZ_HALF: keep = {{(WORD_W-2*LANE_W){1'b0}}, {(2*LANE_W){1'b1}}};
         SZ_WORD: keep = '1;
         default: keep = '0;
      endcase
   end

   assign data = shifted & keep;

endmodule

// File: rtl/be_word_store.sv
module be_word_store
   import be_mem_pkg::*;
#(
   parameter int WORDS = 16,
   parameter int IDX_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [IDX_W-1:0]  idx,
   input  logic [WORD_W-1:0] wword,
   output logic [WORD_W-1:0] rword
);

   logic [WORD_W-1:0] rd_bus [WORDS];

   // One register per word, each cleared by reset.
   for (genvar g = 0; g < WORDS; g++) begin : g_word
      logic [WORD_W-1:0] word_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            word_q <= '0;
         end else if (we && (idx == IDX_W'(g))) begin
            word_q <= wword;
         end
      end

      assign rd_bus[g] = word_q;
   end

   // Asynchronous select of the addressed word for read and merge.
   always_comb begin
      rword = '0;
      for (int i = 0; i < WORDS; i++) begin
         if (idx == IDX_W'(i)) begin
            rword = rd_bus[i];
         end
      end
   end

endmodule

// File: rtl/be_lane_mem.sv
module be_lane_mem
   import be_mem_pkg::*;
#(
   parameter int WORDS  = 16,
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [1:0]        req_size,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [31:0]       req_wdata,
   output logic              rsp_valid,
   output logic              rsp_err,
   output logic [31:0]       rsp_rdata
);

   localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1;

   // Elaboration-time parameter checks.
   initial begin
      assert (WORDS >= 1)
         else $error("be_lane_mem: WORDS must be at least 1");
      assert (ADDR_W >= IDX_W + 2)
         else $error("be_lane_mem: ADDR_W too small for WORDS");
      assert (ADDR_W <= 32)
         else $error("be_lane_mem: ADDR_W above 32");
      assert (WORD_W == 32)
         else $error("be_lane_mem: word width must be 32");
   end

   xfer_size_e        size_e;
   logic [IDX_W-1:0]  idx;
   lane_dec_t         dec;
   logic [WORD_W-1:0] cur_word;
   logic [WORD_W-1:0] merged;
   logic [WORD_W-1:0] rd_val;
   logic              wr_fire;
   logic              rd_fire;

   assign size_e  = xfer_size_e'(req_size);
   assign wr_fire = req_valid &  req_write & dec.acc_ok;
   assign rd_fire = req_valid & ~req_write & dec.acc_ok;

   be_addr_decode #(
      .WORDS  (WORDS),
      .ADDR_W (ADDR_W),
      .IDX_W  (IDX_W)
   ) u_dec (
      .addr (req_addr),
      .size (size_e),
      .idx  (idx),
      .dec  (dec)
   );

   be_word_store #(
      .WORDS (WORDS),
      .IDX_W (IDX_W)
   ) u_store (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (wr_fire),
      .idx   (idx),
      .wword (merged),
      .rword (cur_word)
   );

   be_lane_merge u_merge (
      .old_word (cur_word),
      .wdata    (req_wdata),
      .size     (size_e),
      .lane_en  (dec.lane_en),
      .new_word (merged)
   );

   be_lane_extract u_extract (
      .word   (cur_word),
      .rshift (dec.rshift),
      .size   (size_e),
      .data   (rd_val)
   );

   // Registered response, one cycle after the request.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_err   <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         rsp_valid <= req_valid;
         rsp_err   <= req_valid & dec.acc_err;
         rsp_rdata <= rd_fire ? rd_val : '0;
      end
   end

endmodule

// File: rtl/be_lane_mem_chk.sv
module be_lane_mem_chk #(
   parameter int WORDS  = 16,
   parameter int ADDR_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_write,
   input logic [1:0]        req_size,
   input logic [ADDR_W-1:0] req_addr,
   input logic              rsp_valid,
   input logic              rsp_err,
   input logic [31:0]       rsp_rdata
);

   logic beyond;
   assign beyond = (32'(req_addr) >> 2) >= 32'(WORDS);

   assert_valid_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);

   assert_no_spurious_rsp_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);

   assert_err_only_with_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_err |-> rsp_valid);

   assert_write_rsp_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_write) |=> (rsp_rdata == 32'd0));

   assert_byte_zero_ext_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_write && req_size == 2'd0) |=> (rsp_rdata[31:8] == 24'd0));

   assert_half_zero_ext_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_write && req_size == 2'd1) |=> (rsp_rdata[31:16] == 16'd0));

   assert_misalign_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && ((req_size == 2'd1 && req_addr[0]) ||
                     (req_size == 2'd2 && req_addr[1:0] != 2'b00)))
      |=> (rsp_err && rsp_rdata == 32'd0));

   assert_range_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_size != 2'd3 && beyond) |=> (rsp_err && rsp_rdata == 32'd0));

   assert_noop_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_size == 2'd3) |=> (!rsp_err && rsp_rdata == 32'd0));

   assert_err_zero_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_err |-> (rsp_rdata == 32'd0));

endmodule

bind be_lane_mem be_lane_mem_chk #(
   .WORDS  (WORDS),
   .ADDR_W (ADDR_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_write (req_write),
   .req_size  (req_size),
   .req_addr  (req_addr),
   .rsp_valid (rsp_valid),
   .rsp_err   (rsp_err),
   .rsp_rdata (rsp_rdata)
);

// File: tb/be_lane_mem_bench.sv
`timescale 1ns/1ps
module be_lane_mem_bench;

   localparam int WORDS  = 16;
   localparam int ADDR_W = 8;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              req_valid = 1'b0;
   logic              req_write = 1'b0;
   logic [1:0]        req_size = 2'd0;
   logic [ADDR_W-1:0] req_addr = '0;
   logic [31:0]       req_wdata = '0;
   logic              rsp_valid;
   logic              rsp_err;
   logic [31:0]       rsp_rdata;

   int unsigned total = 0;
   int unsigned bad   = 0;
   bit          done  = 1'b0;

   logic [31:0] refm [WORDS];

   always #10 clk = ~clk;

   be_lane_mem #(.WORDS(WORDS), .ADDR_W(ADDR_W)) u_be_lane_mem (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_write (req_write),
      .req_size  (req_size),
      .req_addr  (req_addr),
      .req_wdata (req_wdata),
      .rsp_valid (rsp_valid),
      .rsp_err   (rsp_err),
      .rsp_rdata (rsp_rdata)
   );

   task automatic check(input string tag, input bit ev, input bit ee, input logic [31:0] ed);
      total++;
      if (rsp_valid !== ev || rsp_err !== ee || rsp_rdata !== ed) begin
         bad++;
         $display("FAIL %s: got valid=%0b err=%0b data=%08h, expected valid=%0b err=%0b data=%08h",
                  tag, rsp_valid, rsp_err, rsp_rdata, ev, ee, ed);
      end
   endtask

   function automatic bit refused(input int sz, input int a);
      if (sz == 3) return 1'b0;
      if (sz == 1 && (a % 2) != 0) return 1'b1;
      if (sz == 2 && (a % 4) != 0) return 1'b1;
      return (a / 4) >= WORDS;
   endfunction

   function automatic logic [31:0] model_read(input int sz, input int a);
      logic [31:0] w;
      w = refm[a / 4];
      case (sz)
         0: return (w >> ((3 - (a % 4)) * 8)) & 32'h0000_00ff;
         1: return ((a % 4) >= 2) ? (w & 32'h0000_ffff) : (w >> 16);
         2: return w;
         default: return 32'd0;
      endcase
   endfunction

   task automatic model_write(input int sz, input int a, input logic [31:0] d);
      int          sh;
      logic [31:0] mask;
      case (sz)
         0: begin
            sh   = (3 - (a % 4)) * 8;
            mask = 32'h0000_00ff << sh;
            refm[a / 4] = (refm[a / 4] & ~mask) | ((d & 32'h0000_00ff) << sh);
         end
         1: begin
            if ((a % 4) >= 2) refm[a / 4] = {refm[a / 4][31:16], d[15:0]};
            else              refm[a / 4] = {d[15:0], refm[a / 4][15:0]};
         end
         2: refm[a / 4] = d;
         default: ;
      endcase
   endtask

   // One request, checked in the cycle after it is taken.
   task automatic access(input bit wr, input int sz, input int a,
                         input logic [31:0] d, input string tag);
      bit          ee;
      logic [31:0] ed;
      @(negedge clk);
      req_valid = 1'b1;
      req_write = wr;
      req_size  = 2'(sz);
      req_addr  = ADDR_W'(a);
      req_wdata = d;
      ee = refused(sz, a);
      ed = 32'd0;
      if (!ee && sz != 3) begin
         if (wr) model_write(sz, a, d);
         else    ed = model_read(sz, a);
      end
      @(posedge clk);
      #2;
      req_valid = 1'b0;
      check(tag, 1'b1, ee, ed);
   endtask

   task automatic idle(input string tag);
      @(posedge clk);
      #2;
      check(tag, 1'b0, 1'b0, 32'd0);
   endtask

   initial begin
      #4_000_000;
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog: run did not finish, expected end before timeout");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < WORDS; i++) refm[i] = 32'd0;
      repeat (3) @(posedge clk);
      #2;
      check("R6 reset outputs", 1'b0, 1'b0, 32'd0);
      @(negedge clk);
      rst_n = 1'b1;
      idle("R10 idle after reset");

      // R6: every word cleared
      for (int i = 0; i < WORDS; i++) access(1'b0, 2, i * 4, 32'd0, "R6 cleared word");

      // R5/R1: whole-word writes and reads
      access(1'b1, 2, 0,  32'h1122_3344, "R5 word write");
      access(1'b1, 2, 4,  32'hA5A5_5A5A, "R5 word write");
      access(1'b1, 2, 60, 32'hDEAD_BEEF, "R5 word write last");
      access(1'b0, 2, 0,  32'd0, "R1 word read");
      access(1'b0, 2, 60, 32'd0, "R1 word read last");
      idle("R10 idle gap");

      // R2: every byte lane
      for (int k = 0; k < 4; k++) access(1'b0, 0, k, 32'd0, "R2 byte lane read");
      // R3: both halves
      access(1'b0, 1, 0, 32'd0, "R3 upper half read");
      access(1'b0, 1, 2, 32'd0, "R3 lower half read");

      // R4: single-lane merges into a known word
      access(1'b1, 0, 5,  32'hFFFF_FF77, "R4 byte write lane 1");
      access(1'b0, 2, 4,  32'd0, "R4 byte merge result");
      access(1'b1, 1, 6,  32'h1234_BEAD, "R4 half write low");
      access(1'b0, 2, 4,  32'd0, "R4 half merge result");
      access(1'b1, 1, 60, 32'h0000_C0DE, "R4 half write high");
      access(1'b0, 2, 60, 32'd0, "R4 half merge high result");
      for (int k = 0; k < 4; k++) access(1'b1, 0, 8 + k, 32'(8'h10 + k), "R4 byte fill");
      access(1'b0, 2, 8, 32'd0, "R4 byte fill result");

      // R7: misaligned refused, store untouched
      access(1'b1, 2, 2,  32'hFFFF_FFFF, "R7 misaligned word write");
      access(1'b1, 1, 1,  32'hFFFF_FFFF, "R7 misaligned half write");
      access(1'b0, 2, 1,  32'd0, "R7 misaligned word read");
      access(1'b0, 2, 0,  32'd0, "R7 word unchanged");

      // R8: out of range refused
      access(1'b1, 2, 64,  32'hFFFF_FFFF, "R8 range word write");
      access(1'b1, 0, 200, 32'hFFFF_FFFF, "R8 range byte write");
      access(1'b0, 0, 255, 32'd0, "R8 range byte read");
      access(1'b0, 2, 0,  32'd0, "R8 word 0 unchanged");

      // R9: size 3 no-op
      access(1'b1, 3, 4, 32'hFFFF_FFFF, "R9 noop write");
      access(1'b0, 3, 4, 32'd0, "R9 noop read");
      access(1'b0, 2, 4, 32'd0, "R9 word unchanged");

      // Mixed run against the model
      for (int n = 0; n < 600; n++) begin
         int    sz;
         int    a;
         bit    wr;
         string tag;
         sz = int'($urandom % 4);
         a  = int'($urandom % 80);
         wr = 1'($urandom);
         if (($urandom % 4) != 0) begin
            if (sz == 1) a = a & ~1;
            if (sz == 2) a = a & ~3;
         end
         if (sz == 3)                                 tag = "R9 mixed";
         else if ((a / 4) >= WORDS)                   tag = "R8 mixed";
         else if (refused(sz, a))                     tag = "R7 mixed";
         else if (wr && sz == 2)                      tag = "R5 mixed";
         else if (wr)                                 tag = "R4 mixed";
         else if (sz == 0)                            tag = "R2 mixed";
         else if (sz == 1)                            tag = "R3 mixed";
         else                                         tag = "R1 mixed";
         access(wr, sz, a, $urandom, tag);
         if ((n % 50) == 0) idle("R10 mixed idle");
      end

      for (int i = 0; i < WORDS; i++) access(1'b0, 2, i * 4, 32'd0, "R1 final readback");

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule